// File: doc/BRIEF.md
# ARINC 429 Word Repetition Scheduler

This block decides the moments at which an ARINC 429 transmitter starts a word. It watches an asynchronous transmit-enable line, an 8-bit interval code and a rate select, and it issues a one-clock start strobe to the transmitter. The transmitter reports back through a busy flag. The block serves two uses that share one input. A rising edge on the enable line sends a single word. Holding the enable line high repeats the word at a programmed interval.

An interval code from 1 to 255 sets a repetition period of that many 10 ms ticks. A code of zero selects back-to-back operation, in which a word starts every 36 bit times: 32 data bits and a 4-bit gap. The bit time depends on the rate select. After reset, a hold-off window keeps the output quiet so that data that has not settled is never sent. The block runs from a 1 MHz clock. Parameters give the clock counts of a tick, of each bit time and of the hold-off, so a simulation can shorten them.

Top module: `word_repeat_sched`

## Requirements
- R1: While reset is high, `start_o` is 0. For the first HOLDOFF_TICKS×TICK_CYCLES clock cycles after reset is released, no strobe is issued, and enable edges that arrive in that window are discarded.
- R2: If enable is high when the hold-off ends, the first strobe comes HOLDOFF_TICKS×TICK_CYCLES+1 cycles after reset release. Periodic repetition follows from that strobe.
- R3: Enable passes through a two-flop synchronizer. A rising edge, even a one- or two-cycle high pulse, yields exactly one strobe 3 cycles after the input changes.
- R4: While enable is low, no strobe is issued and the interval timer is cleared.
- R5: While enable stays high with interval code N in 1..255, strobes repeat every N×TICK_CYCLES cycles.
- R6: With interval code 0, strobes repeat every 36 bit times: 36×BIT_FAST_CYCLES cycles when `fast_i`=1 and 36×BIT_SLOW_CYCLES cycles when `fast_i`=0.
- R7: The interval code and rate select are captured when each interval starts. A change made during an interval takes effect from the next interval.
- R8: A rising edge that arrives while the transmitter is busy sends no word, but it restarts the interval timer from zero. A word then follows at interval completion only if enable is still high.
- R9: Rising edges spaced wider than a word time each produce a strobe, and each one restarts the interval timer.
- R10: `start_o` is never high for two consecutive cycles, and it is never raised in the cycle after `tx_busy_i` was seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock (1 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_i | input | 1 | Asynchronous transmit enable: edge sends once, level repeats |
| interval_code_i | input | 8 | Repetition code: 0 = back-to-back, N = N ticks |
| fast_i | input | 1 | Rate select: 1 = high bit rate, 0 = low bit rate |
| tx_busy_i | input | 1 | Transmitter is shifting a word |
| start_o | output | 1 | One-cycle strobe to start a word |

## Verification
The assertions assume that `tx_busy_i` rises no later than the cycle after a strobe and stays high until the word has left. Without that, the busy guard has no meaning. The assertions also assume that the enable level seen after synchronization is the only path to a strobe. The bench models a transmitter that raises busy half a cycle after each strobe and holds it for 32 bit times. Every interval the bench uses is longer than that, so periodic completions never collide with a busy word. The one exception is the case the bench makes on purpose, where an edge arrives during the busy window.

// File: rtl/wsch_pkg.sv
package wsch_pkg;
  // Bit slots per word including the inter-word gap.
  localparam int WORD_SLOTS = 36;

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/wsch_en_sync.sv
module wsch_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign level_o = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_o <= 1'b0;
    else     prev_o <= level_o;
  end
endmodule

// File: rtl/wsch_holdoff.sv
module wsch_holdoff #(
  parameter int HOLD_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  output logic ready_o,
  output logic first_o
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic ready_d;

  generate
    if (HOLD_CYC == 0) begin : g_none
      assign ready_o = 1'b1;
    end else begin : g_count
      logic [HW-1:0] cnt_q;
      logic          ready_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q   <= '0;
          ready_q <= 1'b0;
        end else if (!ready_q) begin
          if (cnt_q == HW'(HOLD_CYC - 1)) ready_q <= 1'b1;
          else                            cnt_q   <= cnt_q + 1'b1;
        end
      end
      assign ready_o = ready_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ready_d <= 1'b0;
    else     ready_d <= ready_o;
  end

  assign first_o = ready_o & ~ready_d;
endmodule

// File: rtl/wsch_interval.sv
module wsch_interval
  import wsch_pkg::*;
#(
  parameter int TICK_CYCLES = 10000,
  parameter int BIT_FAST    = 10,
  parameter int BIT_SLOW    = 80,
  parameter int CODE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              fast_i,
  output logic              done_o
);
  localparam int FAST_WORD = WORD_SLOTS * BIT_FAST;
  localparam int SLOW_WORD = WORD_SLOTS * BIT_SLOW;
  localparam int MAX_TICK  = ((1 << CODE_W) - 1) * TICK_CYCLES;
  localparam int MAX_WORD  = (FAST_WORD > SLOW_WORD) ? FAST_WORD : SLOW_WORD;
  localparam int MAXV      = (MAX_TICK > MAX_WORD) ? MAX_TICK : MAX_WORD;
  localparam int CW        = $clog2(MAXV + 1);

  rate_e          rate;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  target_q;
  logic [CW-1:0]  target_next;
  logic           active_q;
  logic           hit;

  assign rate = rate_e'(fast_i);

  always_comb begin
    if (code_i == '0)
      target_next = (rate == RATE_FAST) ? CW'(FAST_WORD) : CW'(SLOW_WORD);
    else
      target_next = CW'(code_i) * CW'(TICK_CYCLES);
  end

  assign hit    = active_q && (cnt_q == target_q - CW'(1));
  assign done_o = hit && run_i && !load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      target_q <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      target_q <= target_next;
    end else if (!run_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (hit) begin
      cnt_q    <= '0;
      target_q <= target_next;
    end else if (active_q) begin
      cnt_q    <= cnt_q + CW'(1);
    end
  end

  // R5: a running count never passes the captured period.
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < target_q));

  // R7: the captured period changes only when an interval starts.
  a_r7_target_held: assert property (@(posedge clk) disable iff (rst)
    (active_q && run_i && !load_i && !hit) |=> $stable(target_q));

  // R4: a low enable leaves the timer idle.
  a_r4_timer_cleared: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> (!active_q && cnt_q == '0));
endmodule

// File: rtl/word_repeat_sched.sv
module word_repeat_sched
  import wsch_pkg::*;
#(
  parameter int TICK_CYCLES     = 10000,
  parameter int HOLDOFF_TICKS   = 50,
  parameter int BIT_FAST_CYCLES = 10,
  parameter int BIT_SLOW_CYCLES = 80,
  parameter int SYNC_STAGES     = 2,
  parameter int CODE_W          = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en_i,
  input  logic [CODE_W-1:0] interval_code_i,
  input  logic              fast_i,
  input  logic              tx_busy_i,
  output logic              start_o
);
  localparam int HOLD_CYC = HOLDOFF_TICKS * TICK_CYCLES;

  logic en_s, en_prev;
  logic ready, ready_first;
  logic arm, done, fire, start_q;

  wsch_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .din     (tx_en_i),
    .level_o (en_s),
    .prev_o  (en_prev)
  );

  wsch_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .ready_o (ready),
    .first_o (ready_first)
  );

  // A fresh interval starts on a synchronized rising edge, or at the end of
  // the hold-off when enable is already high.
  assign arm = ready & en_s & (~en_prev | ready_first);

  wsch_interval #(
    .TICK_CYCLES (TICK_CYCLES),
    .BIT_FAST    (BIT_FAST_CYCLES),
    .BIT_SLOW    (BIT_SLOW_CYCLES),
    .CODE_W      (CODE_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (arm),
    .run_i  (en_s),
    .code_i (interval_code_i),
    .fast_i (fast_i),
    .done_o (done)
  );

  assign fire = (arm | done) & ~tx_busy_i & ~start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= fire;
  end

  assign start_o = start_q;

  // R1: nothing leaves while the hold-off is running.
  a_r1_quiet_in_holdoff: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !start_o);

  // R4: a strobe needs the synchronized enable high one cycle earlier.
  a_r4_no_word_when_low: assert property (@(posedge clk) disable iff (rst)
    !$past(en_s) |-> !start_o);

  // R10: strobes are single cycles.
  a_r10_single_cycle: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R10, R8: no strobe right after the transmitter reported busy.
  a_r10_respects_busy: assert property (@(posedge clk) disable iff (rst)
    tx_busy_i |=> !start_o);
endmodule

// File: tb/tb_word_repeat_sched.sv
`timescale 1ns/1ps
module tb_word_repeat_sched;
  localparam int TICK = 50;
  localparam int HOLD = 250;
  localparam int BF   = 2;
  localparam int BS   = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic       fast;
  logic [7:0] code;
  logic       tx_busy;
  logic       start;

  always #2.5 clk = ~clk;

  word_repeat_sched #(
    .TICK_CYCLES     (TICK),
    .HOLDOFF_TICKS   (5),
    .BIT_FAST_CYCLES (BF),
    .BIT_SLOW_CYCLES (BS)
  ) dut (
    .clk             (clk),
    .rst             (rst),
    .tx_en_i         (en),
    .interval_code_i (code),
    .fast_i          (fast),
    .tx_busy_i       (tx_busy),
    .start_o         (start)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int   pulses [0:255];
  int   npulse = 0;
  int   bcnt = 0;
  int   viol = 0;
  logic prev_start = 1'b0;
  int   total = 0;
  int   fails = 0;

  assign tx_busy = (bcnt != 0);

  // Transmitter model and strobe recorder.
  always @(negedge clk) begin
    if (start) begin
      if (npulse < 256) pulses[npulse] = cyc;
      npulse++;
      if (prev_start || bcnt != 0) viol++;
      bcnt = fast ? 32 * BF : 32 * BS;
    end else if (bcnt != 0) begin
      bcnt--;
    end
    prev_start = start;
  end

  function automatic int count_in(int lo, int hi);
    int n = 0;
    for (int i = 0; i < npulse && i < 256; i++)
      if (pulses[i] >= lo && pulses[i] <= hi) n++;
    return n;
  endfunction

  function automatic int has(int c);
    return (count_in(c, c) == 1) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    en = 1'b0;
    waitn(150);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int r;
    int m;
    rst = 1'b1; en = 1'b1; fast = 1'b1; code = 8'd2;
    waitn(5);
    chk("R1 strobe low in reset", int'(start), 0);
    rst = 1'b0;
    r = cyc;
    waitn(500);
    chk("R1 quiet during hold-off", count_in(r, r + HOLD), 0);
    chk("R2 first word at hold-off end", has(r + HOLD + 1), 1);
    chk("R5 period code 2 second", has(r + HOLD + 101), 1);
    chk("R5 period code 2 third", has(r + HOLD + 201), 1);
    chk("R5 count code 2", count_in(r, r + 500), 3);

    // R4: enable low stops everything
    m = cyc; en = 1'b0;
    waitn(400);
    chk("R4 no word while low", count_in(m + 1, m + 400), 0);

    // R3: one-cycle pulse
    m = cyc; en = 1'b1;
    waitn(1); en = 1'b0;
    waitn(299);
    chk("R3 one-cycle pulse position", has(m + 3), 1);
    chk("R3 one-cycle pulse count", count_in(m + 1, m + 300), 1);
    settle();

    // R3: two-cycle pulse
    m = cyc; en = 1'b1;
    waitn(2); en = 1'b0;
    waitn(298);
    chk("R3 two-cycle pulse position", has(m + 3), 1);
    chk("R3 two-cycle pulse count", count_in(m + 1, m + 300), 1);
    settle();

    // R5: code 3
    code = 8'd3;
    m = cyc; en = 1'b1;
    waitn(320);
    chk("R5 code 3 first", has(m + 3), 1);
    chk("R5 code 3 second", has(m + 153), 1);
    chk("R5 code 3 third", has(m + 303), 1);
    chk("R5 code 3 count", count_in(m + 1, m + 320), 3);
    settle();

    // R6: code 0, fast rate
    code = 8'd0;
    m = cyc; en = 1'b1;
    waitn(160);
    chk("R6 fast back-to-back 2nd", has(m + 75), 1);
    chk("R6 fast back-to-back 3rd", has(m + 147), 1);
    chk("R6 fast count", count_in(m + 1, m + 160), 3);
    settle();

    // R6: code 0, slow rate
    fast = 1'b0;
    waitn(5);
    m = cyc; en = 1'b1;
    waitn(300);
    chk("R6 slow back-to-back 2nd", has(m + 147), 1);
    chk("R6 slow back-to-back 3rd", has(m + 291), 1);
    chk("R6 slow count", count_in(m + 1, m + 300), 3);
    settle();

    // R8: edge while busy is dropped but restarts the timer (slow, code 0)
    m = cyc; en = 1'b1;
    waitn(20); en = 1'b0;
    waitn(10); en = 1'b1;
    waitn(170);
    chk("R8 busy edge dropped", count_in(m + 4, m + 176), 0);
    chk("R8 word at restarted interval", has(m + 177), 1);
    chk("R8 count", count_in(m + 1, m + 200), 2);
    settle();
    fast = 1'b1;
    waitn(5);

    // R7: code change mid-interval applies next interval
    code = 8'd2;
    m = cyc; en = 1'b1;
    waitn(10); code = 8'd4;
    waitn(300);
    chk("R7 first interval keeps old code", has(m + 103), 1);
    chk("R7 new code next interval", has(m + 303), 1);
    chk("R7 count", count_in(m + 1, m + 310), 3);
    settle();

    // R9: spaced edges each send and restart the timer (code 4)
    m = cyc; en = 1'b1;
    waitn(1); en = 1'b0;
    waitn(99); en = 1'b1;
    waitn(210);
    chk("R9 first edge", has(m + 3), 1);
    chk("R9 second edge", has(m + 103), 1);
    chk("R9 restarted interval", has(m + 303), 1);
    chk("R9 count", count_in(m + 1, m + 310), 3);
    settle();

    // R1/R2: edges in hold-off ignored, level at its end honoured
    rst = 1'b1;
    waitn(3);
    chk("R1 strobe low in second reset", int'(start), 0);
    rst = 1'b0;
    r = cyc;
    waitn(20); en = 1'b1;
    waitn(1);  en = 1'b0;
    waitn(179); en = 1'b1;
    waitn(60);  en = 1'b0;
    waitn(140);
    chk("R1 hold-off edge discarded", count_in(r + 1, r + HOLD), 0);
    chk("R2 word when hold-off ends", has(r + HOLD + 1), 1);
    chk("R2 count", count_in(r + 1, r + 400), 1);

    chk("R10 strobe width and busy guard", viol, 0);
    report();
  end
endmodule